// File: doc/BRIEF.md
# Programmable Bit-Slice Pattern Matcher

This block evaluates boolean conditions over a group of asynchronous input lines and raises interrupts when programmed combinations are seen. It has eight bit slices. Each slice takes one of eight synchronized input lines and tests it against a selectable condition: constant true or false, a high or low level, a latched (sticky) rising, falling or either edge, or a single-cycle event on either edge. Runs of consecutive slices are ANDed into product terms. Endpoint flags mark where each run ends, and slice 7 always closes the last run.

Each product term drives the interrupt line that has the same index as its endpoint slice. A control bit chooses whether the interrupt outputs carry these pattern results or pass through an externally supplied set of standard pin interrupts. When enabled, a receive-event output gives a one-cycle pulse each time any term changes from unmatched to matched. Software programs three write-only words (control, source select, condition) through separate write strobes. It reads the mode, the event enable and the live term-match field back from the control word.

Top module: `patmatch_engine`

## Requirements
- R1: During reset and just after it, all settings are zero: mode 0, event enable 0, every source 0, every condition code 0 and no endpoint flags. rx_event is 0, irq_out equals pin_irq_std, and the match field reads 0. In the first cycle after reset is released, the match field reads 8'h80, because every slice is constant true and only slice 7 is an endpoint.
- R2: A wr_ctrl write stores wr_data[0] as the mode and wr_data[1] as the event enable. ctrl_rdata returns the mode in bit 0, the enable in bit 1 and the term-match state in bits 31:24. All other bits of ctrl_rdata read 0.
- R3: A wr_src write stores, for slice n, the 3-bit field at wr_data[8+3n +: 3]. That field is the index of the line_in bit that feeds the slice.
- R4: A wr_cfg write stores, for slice n, the 3-bit condition code at wr_data[8+3n +: 3]. Code 0 is always true, 4 is true while the line is high, 5 is true while the line is low, and 6 is never true.
- R5: Code 1 latches a rising edge, code 2 a falling edge and code 3 either edge. Once latched, the slice stays true while the line keeps changing. The latch is cleared only by a wr_src or wr_cfg write; a wr_ctrl write leaves it unchanged.
- R6: Code 7 is true for exactly one cycle after each rising or falling edge of the synchronized line. The match bit is therefore high for a single cycle for each edge.
- R7: wr_cfg bits 6:0 mark slices 0 to 6 as endpoints, and slice 7 is always an endpoint. Match bit k is the AND of slices j+1..k, where j is the previous endpoint (or -1 if there is none). Match bits at non-endpoint slices are 0.
- R8: With mode 1, irq_out equals the match field. With mode 0, irq_out equals pin_irq_std.
- R9: When the event enable is 1, rx_event is high for one cycle in the same cycle that any match bit goes from 0 to 1. When the enable is 0, rx_event stays 0.
- R10: A change on line_in appears in the match field after three clock edges: two synchronizer stages and one result register. A condition or endpoint write takes effect on the match field one edge after the write is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 8 | Asynchronous input lines |
| pin_irq_std | input | 8 | Standard pin interrupts, passed through when mode is 0 |
| wr_ctrl | input | 1 | Write strobe for the control word |
| wr_src | input | 1 | Write strobe for the source-select word |
| wr_cfg | input | 1 | Write strobe for the condition/endpoint word |
| wr_data | input | 32 | Write data shared by all three strobes |
| ctrl_rdata | output | 32 | Mode, event enable and match-state readback |
| irq_out | output | 8 | Interrupt outputs |
| rx_event | output | 1 | One-cycle pulse when any term becomes matched |

## Verification
The faults that matter most cannot be seen directly: a sticky latch that is set, a latch that fails to clear, or an endpoint chain that is cut in the wrong place. Each of these shows up in the match field at bits 31:24 of ctrl_rdata, either three edges after a line change or one edge after a write. The bench therefore samples exactly at those cycles. The pulse-type outputs (code 7 results and rx_event) are also checked one cycle later, so that a pulse lasting too long is caught as well as a missing one.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
   typedef enum logic [2:0] {
      COND_ONE     = 3'd0,
      COND_RISE_ST = 3'd1,
      COND_FALL_ST = 3'd2,
      COND_ANY_ST  = 3'd3,
      COND_HIGH    = 3'd4,
      COND_LOW     = 3'd5,
      COND_NONE    = 3'd6,
      COND_PULSE   = 3'd7
   } pm_cond_e;

   localparam int FIELD_W   = 3;
   localparam int FIELD_LSB = 8;
   localparam int MATCH_LSB = 24;
endpackage

// File: rtl/pm_sync_edge.sv
`timescale 1ns/1ps
module pm_sync_edge #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pm_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= din;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign lvl  = stg_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pm_slice.sv
`timescale 1ns/1ps
module pm_slice #(
   parameter int NUM_LINES = 8,
   localparam int SRC_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [NUM_LINES-1:0] lvl,
   input  logic [NUM_LINES-1:0] rise,
   input  logic [NUM_LINES-1:0] fall,
   input  logic [SRC_W-1:0]     src,
   input  pm_pkg::pm_cond_e     cond,
   output logic                 hit
);
   import pm_pkg::*;

   logic l, r, f, ev, st_q;

   assign l = lvl[src];
   assign r = rise[src];
   assign f = fall[src];

   always_comb begin
      case (cond)
         COND_RISE_ST: ev = r;
         COND_FALL_ST: ev = f;
         COND_ANY_ST:  ev = r | f;
         default:      ev = 1'b0;
      endcase
   end

   // sticky latch: set by the selected edge, cleared only by a setting write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= 1'b0;
      else if (clr) st_q <= 1'b0;
      else if (ev)  st_q <= 1'b1;
   end

   always_comb begin
      case (cond)
         COND_ONE:     hit = 1'b1;
         COND_RISE_ST: hit = st_q | ev;
         COND_FALL_ST: hit = st_q | ev;
         COND_ANY_ST:  hit = st_q | ev;
         COND_HIGH:    hit = l;
         COND_LOW:     hit = ~l;
         COND_NONE:    hit = 1'b0;
         COND_PULSE:   hit = r | f;
      endcase
   end
endmodule

// File: rtl/pm_term_chain.sv
`timescale 1ns/1ps
module pm_term_chain #(
   parameter int NUM_SLICES = 8
) (
   input  logic [NUM_SLICES-1:0] hit,
   input  logic [NUM_SLICES-1:0] endpt,
   output logic [NUM_SLICES-1:0] term
);
   logic [NUM_SLICES-1:0] run;

   genvar k;
   generate
      for (k = 0; k < NUM_SLICES; k++) begin : g_chain
         if (k == 0) begin : g_first
            assign run[k] = hit[k];
         end else begin : g_next
            // a fresh product starts right after an endpoint
            assign run[k] = hit[k] & (endpt[k-1] | run[k-1]);
         end
         assign term[k] = endpt[k] & run[k];
      end
   endgenerate
endmodule

// File: rtl/patmatch_engine.sv
`timescale 1ns/1ps
module patmatch_engine #(
   parameter int NUM_SLICES  = 8,
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SRC_W      = $clog2(NUM_LINES),
   localparam int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINES-1:0]  line_in,
   input  logic [NUM_SLICES-1:0] pin_irq_std,
   input  logic                  wr_ctrl,
   input  logic                  wr_src,
   input  logic                  wr_cfg,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     ctrl_rdata,
   output logic [NUM_SLICES-1:0] irq_out,
   output logic                  rx_event
);
   import pm_pkg::*;

   generate
      if (NUM_SLICES < 2 || NUM_SLICES > 8) begin : g_bad_slices
         $error("patmatch_engine: NUM_SLICES must be 2..8");
      end
      if (SRC_W > FIELD_W || NUM_LINES < 2) begin : g_bad_lines
         $error("patmatch_engine: NUM_LINES must be 2..8");
      end
      if (FIELD_LSB + FIELD_W * NUM_SLICES > DATA_W) begin : g_bad_fields
         $error("patmatch_engine: fields exceed the data word");
      end
   endgenerate

   logic                              mode_q, evt_en_q;
   logic [NUM_SLICES-1:0][SRC_W-1:0]  src_q;
   logic [NUM_SLICES-1:0][FIELD_W-1:0] cond_q;
   logic [NUM_SLICES-2:0]             ep_q;
   logic [NUM_SLICES-1:0]             match_q;
   logic                              evt_q;
   logic                              clr;
   logic [NUM_LINES-1:0]              lvl, rise, fall;
   logic [NUM_SLICES-1:0]             hit, term;
   logic                              unused_data;

   assign unused_data = ^wr_data;
   assign clr = wr_src | wr_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 1'b0;
         evt_en_q <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q   <= wr_data[0];
         evt_en_q <= wr_data[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
      end else if (wr_src) begin
         for (int n = 0; n < NUM_SLICES; n++)
            src_q[n] <= wr_data[FIELD_LSB + FIELD_W*n +: SRC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= '0;
         ep_q   <= '0;
      end else if (wr_cfg) begin
         for (int n = 0; n < NUM_SLICES; n++)
            cond_q[n] <= wr_data[FIELD_LSB + FIELD_W*n +: FIELD_W];
         ep_q <= wr_data[NUM_SLICES-2:0];
      end
   end

   pm_sync_edge #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_in),
      .lvl  (lvl),
      .rise (rise),
      .fall (fall)
   );

   genvar n;
   generate
      for (n = 0; n < NUM_SLICES; n++) begin : g_slice
         pm_slice #(.NUM_LINES(NUM_LINES)) u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .lvl  (lvl),
            .rise (rise),
            .fall (fall),
            .src  (src_q[n]),
            .cond (pm_cond_e'(cond_q[n])),
            .hit  (hit[n])
         );
      end
   endgenerate

   pm_term_chain #(.NUM_SLICES(NUM_SLICES)) u_chain (
      .hit  (hit),
      .endpt({1'b1, ep_q}),
      .term (term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
         evt_q   <= 1'b0;
      end else begin
         match_q <= term;
         evt_q   <= evt_en_q & |(term & ~match_q);
      end
   end

   always_comb begin
      ctrl_rdata                          = '0;
      ctrl_rdata[0]                       = mode_q;
      ctrl_rdata[1]                       = evt_en_q;
      ctrl_rdata[MATCH_LSB +: NUM_SLICES] = match_q;
   end

   assign irq_out  = mode_q ? match_q : pin_irq_std;
   assign rx_event = evt_q;
endmodule

// File: rtl/pm_checker.sv
`timescale 1ns/1ps
module pm_checker #(
   parameter int NUM_SLICES = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_cfg,
   input logic [31:0]                  ctrl_rdata,
   input logic                         rx_event,
   input logic [NUM_SLICES-2:0]        ep_q,
   input logic [NUM_SLICES-1:0][2:0]   cond_q
);
   logic [NUM_SLICES-1:0] mstate;
   assign mstate = ctrl_rdata[24 +: NUM_SLICES];

   // R9: a pulse needs the enable from the cycle it was formed in
   p_evt_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> $past(ctrl_rdata[1]));

   // R9: a pulse coincides with some match bit turning on
   p_evt_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> ((mstate & ~$past(mstate)) != '0));

   // R7: only endpoint slices can report a match
   p_match_at_endpt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mstate & ~{1'b1, $past(ep_q)}) == '0);

   // R4: a never-true last slice blocks the last term
   p_never_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_q[NUM_SLICES-1] == pm_pkg::COND_NONE && !wr_cfg) |=> !mstate[NUM_SLICES-1]);
endmodule

bind patmatch_engine pm_checker #(.NUM_SLICES(NUM_SLICES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_cfg    (wr_cfg),
   .ctrl_rdata(ctrl_rdata),
   .rx_event  (rx_event),
   .ep_q      (ep_q),
   .cond_q    (cond_q)
);

// File: tb/patmatch_engine_tb.sv
`timescale 1ns/1ps
module patmatch_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  line_in = '0;
   logic [7:0]  pin_irq_std = '0;
   logic        wr_ctrl = 1'b0, wr_src = 1'b0, wr_cfg = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_rdata;
   logic [7:0]  irq_out;
   logic        rx_event;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   patmatch_engine u_dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .pin_irq_std(pin_irq_std),
      .wr_ctrl(wr_ctrl), .wr_src(wr_src), .wr_cfg(wr_cfg), .wr_data(wr_data),
      .ctrl_rdata(ctrl_rdata), .irq_out(irq_out), .rx_event(rx_event)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int which, input logic [31:0] d);
      wr_data = d;
      wr_ctrl = (which == 0);
      wr_src  = (which == 1);
      wr_cfg  = (which == 2);
      @(posedge clk);
      @(negedge clk);
      wr_ctrl = 1'b0; wr_src = 1'b0; wr_cfg = 1'b0;
   endtask

   function automatic logic [23:0] f8(input logic [2:0] a0, a1, a2, a3, a4, a5, a6, a7);
      return {a7, a6, a5, a4, a3, a2, a1, a0};
   endfunction

   function automatic logic [7:0] mf();
      return ctrl_rdata[31:24];
   endfunction

   task automatic t_reset;
      pin_irq_std = 8'h3C;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 rdata in reset", ctrl_rdata, 32'h0);
      chk("R1 rx_event in reset", {31'b0, rx_event}, 32'h0);
      chk("R1 irq in reset", {24'b0, irq_out}, 32'h3C);
      rst_n = 1'b1;
      step(1);
      chk("R1 match after reset", {24'b0, mf()}, 32'h80);
      chk("R1 ctrl bits after reset", {30'b0, ctrl_rdata[1:0]}, 32'h0);
      chk("R1 irq follows std", {24'b0, irq_out}, 32'h3C);
   endtask

   task automatic t_ctrl;
      wr(0, 32'h0000_0003);
      chk("R2 ctrl readback", {8'b0, ctrl_rdata[23:0]}, 32'h3);
      wr(0, 32'h0000_0001);
      chk("R2 ctrl readback mode only", {8'b0, ctrl_rdata[23:0]}, 32'h1);
   endtask

   task automatic t_level;
      line_in = 8'b0000_0101;
      wr(1, {f8(7, 6, 5, 4, 3, 2, 1, 0), 8'h00});
      wr(2, {f8(4, 4, 4, 4, 4, 4, 4, 4), 1'b0, 7'h7F});
      step(3);
      chk("R3 source select high", {24'b0, mf()}, 32'hA0);
      chk("R8 irq carries match", {24'b0, irq_out}, 32'hA0);
      wr(2, {f8(5, 5, 5, 5, 5, 5, 5, 5), 1'b0, 7'h7F});
      step(1);
      chk("R4 low level", {24'b0, mf()}, 32'h5F);
   endtask

   task automatic t_const;
      wr(2, {f8(0, 6, 6, 6, 6, 6, 6, 6), 1'b0, 7'h7F});
      step(1);
      chk("R4 const one and never", {24'b0, mf()}, 32'h01);
   endtask

   task automatic t_sticky;
      line_in = 8'h02;
      step(3);
      wr(1, {f8(0, 1, 2, 0, 0, 0, 0, 0), 8'h00});
      wr(2, {f8(1, 2, 3, 6, 6, 6, 6, 6), 1'b0, 7'h7F});
      step(3);
      chk("R5 no edge yet", {24'b0, mf()}, 32'h00);
      line_in = 8'h03; step(3);
      chk("R5 rise latched", {24'b0, mf()}, 32'h01);
      line_in = 8'h02; step(3);
      chk("R5 rise held after fall", {24'b0, mf()}, 32'h01);
      line_in = 8'h00; step(3);
      chk("R5 fall latched", {24'b0, mf()}, 32'h03);
      line_in = 8'h04; step(3);
      chk("R5 either latched", {24'b0, mf()}, 32'h07);
      wr(0, 32'h0000_0001);
      step(1);
      chk("R5 ctrl write keeps latches", {24'b0, mf()}, 32'h07);
      wr(2, {f8(1, 2, 3, 6, 6, 6, 6, 6), 1'b0, 7'h7F});
      step(1);
      chk("R5 cfg write clears latches", {24'b0, mf()}, 32'h00);
   endtask

   task automatic t_event;
      line_in = 8'h00;
      wr(1, {f8(0, 0, 0, 3, 0, 0, 0, 0), 8'h00});
      wr(2, {f8(6, 6, 6, 7, 6, 6, 6, 6), 1'b0, 7'h7F});
      step(3);
      chk("R6 idle", {24'b0, mf()}, 32'h00);
      line_in = 8'h08; step(3);
      chk("R6 pulse on rise", {24'b0, mf()}, 32'h08);
      step(1);
      chk("R6 pulse one cycle", {24'b0, mf()}, 32'h00);
      line_in = 8'h00; step(3);
      chk("R6 pulse on fall", {24'b0, mf()}, 32'h08);
      step(1);
      chk("R6 fall pulse one cycle", {24'b0, mf()}, 32'h00);
   endtask

   task automatic t_terms;
      line_in = 8'h00;
      wr(1, {f8(0, 1, 2, 3, 4, 5, 6, 7), 8'h00});
      wr(2, {f8(4, 4, 4, 4, 4, 4, 4, 4), 1'b0, 7'h04});
      step(3);
      chk("R7 all low", {24'b0, mf()}, 32'h00);
      line_in = 8'h07; step(2);
      chk("R10 not yet visible", {24'b0, mf()}, 32'h00);
      step(1);
      chk("R7 first term", {24'b0, mf()}, 32'h04);
      line_in = 8'hF8; step(3);
      chk("R7 last term", {24'b0, mf()}, 32'h80);
      line_in = 8'h03; step(3);
      chk("R7 partial term", {24'b0, mf()}, 32'h00);
      line_in = 8'hFF; step(3);
      chk("R7 both terms", {24'b0, mf()}, 32'h84);
   endtask

   task automatic t_mode;
      pin_irq_std = 8'h5A;
      wr(0, 32'h0000_0000);
      chk("R8 mode 0 passes std", {24'b0, irq_out}, 32'h5A);
      chk("R8 match still read", {24'b0, mf()}, 32'h84);
      wr(0, 32'h0000_0001);
      chk("R8 mode 1 passes match", {24'b0, irq_out}, 32'h84);
   endtask

   task automatic t_rxev;
      line_in = 8'h00;
      wr(0, 32'h0000_0003);
      wr(1, {f8(0, 0, 0, 0, 0, 0, 0, 0), 8'h00});
      wr(2, {f8(4, 0, 0, 0, 0, 0, 0, 0), 1'b0, 7'h00});
      step(3);
      chk("R9 idle", {23'b0, rx_event, mf()}, 32'h000);
      line_in = 8'h01; step(3);
      chk("R9 pulse with match", {23'b0, rx_event, mf()}, 32'h180);
      step(1);
      chk("R9 pulse one cycle", {23'b0, rx_event, mf()}, 32'h080);
      wr(0, 32'h0000_0001);
      line_in = 8'h00; step(3);
      line_in = 8'h01; step(3);
      chk("R9 disabled no pulse", {23'b0, rx_event, mf()}, 32'h080);
   endtask

   initial begin
      t_reset();
      t_ctrl();
      t_level();
      t_const();
      t_sticky();
      t_event();
      t_terms();
      t_mode();
      t_rxev();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule